// File: doc/BRIEF.md
# Oversampling serial frame receiver

This block turns an asynchronous serial line into characters. A clock enable pulses eight times per bit period. The block waits for the idle-high line to go low and confirms the start bit halfway through it. It then collects 5 to 8 data bits, least significant bit first, and checks an optional parity bit and one or two stop bits. The finished character is handed to a downstream receive queue with a one-cycle push strobe.

One error bit goes with each character. It is set by a parity mismatch, a low stop bit or a break, and these causes are not told apart. When the queue reports full at the moment a character completes, the character is dropped and a one-cycle overrun pulse is raised instead. A loopback select takes the line from the local transmitter's output instead of the external pin. The frame settings must be held steady while a frame is in flight.

Top module: `uart_rx_8x`

## Requirements
- R1: After reset, `push` and `overrun` are 0 and `push_data` and `push_err` are 0.
- R2: A low line seen on a `tick` while idle starts a frame. The start bit is confirmed on the 4th following tick. If the line is high by then, the start is dropped and nothing is pushed, so a low glitch of 3 ticks produces no character.
- R3: Each bit lasts 8 ticks, and each later bit is sampled 8 ticks after the one before.
- R4: `width_sel` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Bits are assembled LSB first into `push_data`, and the bits above the selected width are 0.
- R5: `parity_sel[2]`=0 means no parity bit. Codes 4, 5, 6 and 7 mean odd, mark (1), even and space (0). Odd and even count only the selected data bits.
- R6: `two_stop`=0 expects one stop bit and `two_stop`=1 expects two. A low level at any stop sample is a framing error.
- R7: `push_err` is 1 for a parity mismatch, a framing error or a break (all bits low), and the character is still pushed. Otherwise it is 0.
- R8: If `fifo_full` is 1 when a character completes, `overrun` pulses for one cycle and `push` stays 0.
- R9: With `loop_en`=1 the receiver takes its line from `tx_loop`, and `rx_pin` has no effect.
- R10: `push` and `overrun` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick | input | 1 | oversampling enable, 8 per bit |
| width_sel | input | 2 | data bits minus 5 |
| parity_sel | input | 3 | parity mode |
| two_stop | input | 1 | two stop bits expected |
| loop_en | input | 1 | take line from transmitter |
| rx_pin | input | 1 | external serial line |
| tx_loop | input | 1 | local transmitter output |
| fifo_full | input | 1 | receive queue cannot accept |
| push | output | 1 | character valid strobe |
| push_data | output | 8 | received character, zero-extended |
| push_err | output | 1 | parity, framing or break fault |
| overrun | output | 1 | character dropped, queue full |

## Verification
The hardest cases to reach from the ports are a fault in the second stop bit and a break that the receiver must finish without chaining straight into a phantom second character. The bench builds every frame bit by bit on the tick grid. It can corrupt the parity bit, the first stop bit or the second stop bit separately. A break is driven for exactly one frame length and then released, so a single flagged all-zero character is expected. A sweep over all widths, parity modes and stop settings, with data patterns computed per case, covers the normal path.

// File: rtl/uart_rx_8x.sv
module uart_rx_8x #(
  parameter int OSR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] width_sel,
  input  logic [2:0] parity_sel,
  input  logic       two_stop,
  input  logic       loop_en,
  input  logic       rx_pin,
  input  logic       tx_loop,
  input  logic       fifo_full,
  output logic       push,
  output logic [7:0] push_data,
  output logic       push_err,
  output logic       overrun
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic [1:0]    sync;
  logic          perr, ferr, stop2;
  logic          rx, par_bit, fe_now;
  logic [2:0]    last_bit;

  assign rx       = sync[1];
  assign last_bit = {1'b0, width_sel} + 3'd4;
  assign par_bit  = parity_sel[1] ? (parity_sel[0] ? 1'b0 : ^shreg)
                                  : (parity_sel[0] ? 1'b1 : ~^shreg);
  assign fe_now   = ferr | ~rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], loop_en ? tx_loop : rx_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
      stop2     <= 1'b0;
      push      <= 1'b0;
      push_data <= '0;
      push_err  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      push    <= 1'b0;
      overrun <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (rx) begin
                st <= S_IDLE;
              end else begin
                st    <= S_DATA;
                bitn  <= '0;
                shreg <= '0;
                perr  <= 1'b0;
                ferr  <= 1'b0;
                stop2 <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt         <= '0;
              shreg[bitn] <= rx;
              if (bitn == last_bit) st <= parity_sel[2] ? S_PAR : S_STOP;
              else bitn <= bitn + 3'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              perr <= (rx != par_bit);
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (two_stop && !stop2) begin
                stop2 <= 1'b1;
                ferr  <= fe_now;
              end else begin
                st <= S_IDLE;
                if (fifo_full) begin
                  overrun <= 1'b1;
                end else begin
                  push      <= 1'b1;
                  push_data <= shreg;
                  push_err  <= perr | fe_now;
                end
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_8x_chk.sv
module uart_rx_8x_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_full,
  input logic [1:0] width_sel,
  input logic       push,
  input logic [7:0] push_data,
  input logic       overrun
);
  // R10
  push_ovr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && overrun));
  // R10
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
  // R8
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fifo_full));
  // R8
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((push_data & ~(8'hFF >> (3'd3 - {1'b0, width_sel}))) == 8'h00));
endmodule

bind uart_rx_8x uart_rx_8x_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .width_sel(width_sel),
  .push(push), .push_data(push_data), .overrun(overrun)
);

// File: tb/tb_uart_rx_8x.sv
module tb_uart_rx_8x;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div = 2'd1;
  logic       tick;
  logic [1:0] cfg_w = 2'd3;
  logic [2:0] cfg_p = 3'd0;
  logic       cfg_two = 1'b0;
  logic       loop = 1'b0;
  logic       ser = 1'b1;
  logic       full = 1'b0;
  logic       rx_pin, tx_loop;
  logic       push, push_err, overrun;
  logic [7:0] push_data;

  int checks = 0, errors = 0;
  int n_push = 0, n_ovr = 0;
  logic [7:0] last_d = 8'h00;
  logic       last_e = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign tick    = (div == 2'd0);
  assign rx_pin  = loop ? 1'b0 : ser;
  assign tx_loop = loop ? ser : 1'b1;

  uart_rx_8x dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .width_sel(cfg_w),
    .parity_sel(cfg_p), .two_stop(cfg_two), .loop_en(loop), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .fifo_full(full), .push(push), .push_data(push_data),
    .push_err(push_err), .overrun(overrun)
  );

  always @(negedge clk) if (rst_n) begin
    if (push) begin n_push++; last_d = push_data; last_e = push_err; end
    if (overrun) n_ovr++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic bitp(input logic v);
    ser = v;
    repeat (8) wait_tick();
  endtask

  function automatic logic [7:0] mask(input logic [1:0] w);
    return 8'hFF >> (3 - w);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [2:0] p);
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (p[1:0])
      2'd0: return (ones % 2) == 0;
      2'd1: return 1'b1;
      2'd2: return (ones % 2) == 1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop);
    int nb;
    nb = int'(cfg_w) + 5;
    bitp(1'b0);
    for (int i = 0; i < nb; i++) bitp(d[i]);
    if (cfg_p[2]) bitp(exp_par(d, cfg_p) ^ bad_par);
    bitp(bad_stop != 1);
    if (cfg_two) bitp(bad_stop != 2);
    ser = 1'b1;
    repeat (16) wait_tick();
  endtask

  task automatic frame_chk(input logic [7:0] raw, input bit bad_par, input int bad_stop,
                           input bit exp_err, input string req);
    int p0;
    logic [7:0] d;
    d = raw & mask(cfg_w);
    p0 = n_push;
    send(d, bad_par, bad_stop);
    chk(n_push - p0 == 1, req, "push count", n_push - p0, 1);
    chk(last_d == d && last_e == exp_err, req, "data/err",
        {last_e, last_d}, {exp_err, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, o0;
    logic [7:0] pat;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(push == 0 && overrun == 0 && push_data == 0 && push_err == 0, "R1",
        "reset outputs", {push, overrun, push_err, push_data}, 0);
    rst_n = 1'b1;
    repeat (8) wait_tick();

    // R3 R4 R5 R6 sweep over all settings
    for (int w = 0; w < 4; w++)
      for (int pi = 0; pi < 5; pi++)
        for (int t = 0; t < 2; t++)
          for (int di = 0; di < 4; di++) begin
            cfg_w = 2'(w);
            cfg_p = (pi == 0) ? 3'd0 : 3'(3 + pi);
            cfg_two = t[0];
            pat = (di == 0) ? 8'h00 : (di == 1) ? 8'hFF : 8'(w*61 + pi*23 + t*17 + di*45);
            frame_chk(pat, 1'b0, 0, 1'b0, "R4_R5_R6_sweep");
          end

    cfg_w = 2'd3; cfg_p = 3'd6; cfg_two = 1'b1;
    // R5 R7 parity mismatch flagged, character kept
    frame_chk(8'h96, 1'b1, 0, 1'b1, "R7_parity");
    cfg_p = 3'd4;
    frame_chk(8'h3B, 1'b1, 0, 1'b1, "R5_odd_bad");
    // R6 R7 first stop low
    frame_chk(8'h5C, 1'b0, 1, 1'b1, "R6_stop1");
    // R6 second stop low
    frame_chk(8'hC5, 1'b0, 2, 1'b1, "R6_stop2");
    // R7 break: one frame of low then release
    cfg_two = 1'b0; cfg_p = 3'd6;
    p0 = n_push;
    ser = 1'b0;
    repeat (11*8) wait_tick();
    ser = 1'b1;
    repeat (40) wait_tick();
    chk(n_push - p0 == 1, "R7", "break push count", n_push - p0, 1);
    chk(last_d == 8'h00 && last_e == 1'b1, "R7", "break data/err", {last_e, last_d}, 9'h100);

    // R2 three-tick glitch rejected
    p0 = n_push;
    ser = 1'b0;
    repeat (3) wait_tick();
    ser = 1'b1;
    repeat (120) wait_tick();
    chk(n_push == p0, "R2", "glitch push count", n_push - p0, 0);
    frame_chk(8'h81, 1'b0, 0, 1'b0, "R2_after_glitch");

    // R8 overrun
    full = 1'b1;
    p0 = n_push; o0 = n_ovr;
    send(8'h42, 1'b0, 0);
    chk(n_ovr - o0 == 1, "R8", "overrun count", n_ovr - o0, 1);
    chk(n_push == p0, "R8", "push when full", n_push - p0, 0);
    full = 1'b0;
    frame_chk(8'h24, 1'b0, 0, 1'b0, "R8_recover");

    // R9 loopback, pin held low and ignored
    loop = 1'b1;
    repeat (4) wait_tick();
    frame_chk(8'hE7, 1'b0, 0, 1'b0, "R9_loop");
    cfg_w = 2'd1; cfg_p = 3'd5;
    frame_chk(8'h2A, 1'b0, 0, 1'b0, "R9_loop_w6");
    p0 = n_push;
    repeat (120) wait_tick();
    chk(n_push == p0, "R9", "idle loop push count", n_push - p0, 0);
    loop = 1'b0;
    repeat (4) wait_tick();
    // R10 no stray strobes seen across run
    chk(n_push > 160, "R10", "push total", n_push, 161);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule